// File: doc/BRIEF.md
# Address Uniqueness Self-Test Controller

This controller exercises a small single-port memory to expose decoder faults in which a write to one address also lands on a second address. After a start pulse it clears the whole array, walks upward through every address checking that each location still reads zero before marking it with all ones, then clears again and repeats the check-and-mark walk downward. A location that is already nonzero when it is checked is a victim of some earlier write.

When a victim is found, the controller records it, clears the memory and repeats the walk in the same direction. This time it reads only the victim before each write. The first time the victim reads nonzero, the address written just before is reported as the aggressor. The controller never writes the victim itself during this search. If the search finishes and the victim never changes, the fault could not be reproduced, and a separate transient status is reported. Results stay on the outputs until the next start.

The memory port is a synchronous-read array. The address presented in one cycle returns its data on the read input in the next cycle.

Top module: `addr_bist`

## Requirements
- R1: After reset, `done`, `busy`, `fail` and `mem_we` are 0 and `fault_kind` is 0.
- R2: A `start` pulse while not busy raises `busy` on the following cycle. A `start` pulse while busy has no effect on the run or on its results.
- R3: On a fault-free memory the run ends with `done`=1, `fail`=0 and `fault_kind`=0, and every location holds all ones.
- R4: If a write to address A also changes address V with A<V, the run ends with `fail`=1 and `fault_kind`=1 (found on the upward walk). It reports `victim_addr`=V, `aggressor_addr`=A, and `fail_data` equal to all ones.
- R5: If a write to address A also changes address V with A>V, the run ends with `fault_kind`=2 (found on the downward walk), `victim_addr`=V and `aggressor_addr`=A.
- R6: If the disturbance seen in the walk does not recur during the search, the run ends with `fault_kind`=3 (transient) and `victim_addr`=V.
- R7: During the aggressor search, no write is ever issued to the victim address.
- R8: Read data is compared exactly one cycle after its address is presented.
- R9: Every walk, including each search walk, is preceded by a clear that writes zero once to every address. A clean run therefore makes 2×depth zero-writes. An upward fault or a transient fault makes 2×depth. A downward fault makes 3×depth.
- R10: After `done` rises, `done` and all result outputs stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (taken only when not busy) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; results valid |
| fail | output | 1 | Run found a fault |
| fault_kind | output | 2 | 0 none, 1 upward, 2 downward, 3 transient |
| victim_addr | output | ADDR_W | Address found disturbed |
| aggressor_addr | output | ADDR_W | Address whose write disturbed the victim |
| fail_data | output | DATA_W | Data read from the victim when first detected |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after address |

## Verification
The bench builds the controller with ADDR_W=3 and DATA_W=8, so the array has eight locations. At that size every ordered aggressor/victim pair can be injected as a persistent alias. This covers all upward and downward cases, including adjacent pairs and the two ends of the array. The bench also injects a one-shot alias for every upward pair, which drives the transient outcome. That outcome depends on the search skipping the victim write. The bench counts zero-writes per run, which confirms the number of clear passes. Clean runs, one of them with a stray start mid-run, bracket the sweep.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_CHK_RD,
    ST_CHK_WR,
    ST_LOC_RD,
    ST_LOC_CMP
  } bist_state_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_ASC   = 2'd1,
    FK_DESC  = 2'd2,
    FK_TRANS = 2'd3
  } fault_kind_e;

endpackage

// File: rtl/bist_addr_seq.sv
module bist_addr_seq #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic              descend,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_step
);

  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  logic [ADDR_W-1:0] idx;

  // Map the walk index to an address in the selected direction.
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] i,
                                                 input logic d);
    return d ? (LAST_IDX - i) : i;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (restart) begin
      idx <= '0;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end

  assign cur_addr  = seq_addr(idx, descend);
  assign last_step = (idx == LAST_IDX);

  // R9: a restart always brings the walk back to its first step
  a_r9_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx == '0));

endmodule

// File: rtl/bist_fsm.sv
module bist_fsm
  import bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last_step,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              seq_restart,
  output logic              seq_step,
  output logic              seq_desc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fault_kind,
  output logic [ADDR_W-1:0] victim_addr,
  output logic [ADDR_W-1:0] aggressor_addr,
  output logic [DATA_W-1:0] fail_data
);

  localparam logic [DATA_W-1:0] ONES = '1;

  bist_state_e       state;
  logic              desc_q;
  logic              locating;
  logic              have_wr;
  logic [ADDR_W-1:0] last_wr;

  // Named events for the assertions and for readability
  logic ev_found;
  logic ev_victim_hit;
  logic ev_skip;

  function automatic logic is_disturbed(input logic [DATA_W-1:0] d);
    return d != '0;
  endfunction

  assign ev_found      = (state == ST_CHK_WR)  && is_disturbed(mem_rdata);
  assign ev_victim_hit = (state == ST_LOC_CMP) && is_disturbed(mem_rdata);
  assign ev_skip       = (state == ST_LOC_CMP) && !ev_victim_hit &&
                         (cur_addr == victim_addr);
  assign seq_desc      = desc_q;

  always_comb begin
    seq_restart = 1'b0;
    seq_step    = 1'b0;
    mem_addr    = cur_addr;
    mem_we      = 1'b0;
    mem_wdata   = '0;
    unique case (state)
      ST_IDLE: seq_restart = start;
      ST_CLEAR: begin
        mem_we      = 1'b1;
        seq_restart = last_step;
        seq_step    = !last_step;
      end
      ST_CHK_RD: ;
      ST_CHK_WR: begin
        if (ev_found) begin
          seq_restart = 1'b1;
        end else begin
          mem_we      = 1'b1;
          mem_wdata   = ONES;
          seq_restart = last_step;
          seq_step    = !last_step;
        end
      end
      ST_LOC_RD: mem_addr = victim_addr;
      ST_LOC_CMP: begin
        if (!ev_victim_hit) begin
          mem_we    = !ev_skip;
          mem_wdata = ONES;
          seq_step  = !last_step;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      busy           <= 1'b0;
      done           <= 1'b0;
      fail           <= 1'b0;
      fault_kind     <= FK_NONE;
      victim_addr    <= '0;
      aggressor_addr <= '0;
      fail_data      <= '0;
      desc_q         <= 1'b0;
      locating       <= 1'b0;
      have_wr        <= 1'b0;
      last_wr        <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state          <= ST_CLEAR;
            busy           <= 1'b1;
            done           <= 1'b0;
            fail           <= 1'b0;
            fault_kind     <= FK_NONE;
            victim_addr    <= '0;
            aggressor_addr <= '0;
            fail_data      <= '0;
            desc_q         <= 1'b0;
            locating       <= 1'b0;
            have_wr        <= 1'b0;
            last_wr        <= '0;
          end
        end
        ST_CLEAR: begin
          if (last_step) state <= locating ? ST_LOC_RD : ST_CHK_RD;
        end
        ST_CHK_RD: state <= ST_CHK_WR;
        ST_CHK_WR: begin
          if (ev_found) begin
            victim_addr <= cur_addr;
            fail_data   <= mem_rdata;
            locating    <= 1'b1;
            state       <= ST_CLEAR;
          end else if (last_step) begin
            if (desc_q) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              desc_q <= 1'b1;
              state  <= ST_CLEAR;
            end
          end else begin
            state <= ST_CHK_RD;
          end
        end
        ST_LOC_RD: state <= ST_LOC_CMP;
        ST_LOC_CMP: begin
          if (ev_victim_hit) begin
            aggressor_addr <= have_wr ? last_wr : victim_addr;
            fault_kind     <= desc_q ? FK_DESC : FK_ASC;
            fail           <= 1'b1;
            state          <= ST_IDLE;
            busy           <= 1'b0;
            done           <= 1'b1;
          end else begin
            if (!ev_skip) begin
              last_wr <= cur_addr;
              have_wr <= 1'b1;
            end
            if (last_step) begin
              fault_kind <= FK_TRANS;
              fail       <= 1'b1;
              state      <= ST_IDLE;
              busy       <= 1'b0;
              done       <= 1'b1;
            end else begin
              state <= ST_LOC_RD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the search never writes the victim
  a_r7_no_victim_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOC_CMP && mem_we) |-> (mem_addr != victim_addr));

  // R1: the memory is left alone outside a run
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  // R10: results hold until the next start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fault_kind) &&
                          $stable(victim_addr) && $stable(aggressor_addr)));

  // R3: a passing finish carries no fault kind
  a_r3_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (fault_kind == FK_NONE));

  // R8: a compare always follows its read by one cycle
  a_r8_compare_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHK_WR) |-> ($past(state) == ST_CHK_RD));

endmodule

// File: rtl/addr_bist.sv
module addr_bist #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fault_kind,
  output logic [ADDR_W-1:0] victim_addr,
  output logic [ADDR_W-1:0] aggressor_addr,
  output logic [DATA_W-1:0] fail_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              seq_restart;
  logic              seq_step;
  logic              seq_desc;
  logic [ADDR_W-1:0] cur_addr;
  logic              last_step;

  bist_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (seq_restart),
    .step      (seq_step),
    .descend   (seq_desc),
    .cur_addr  (cur_addr),
    .last_step (last_step)
  );

  bist_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .cur_addr       (cur_addr),
    .last_step      (last_step),
    .mem_rdata      (mem_rdata),
    .seq_restart    (seq_restart),
    .seq_step       (seq_step),
    .seq_desc       (seq_desc),
    .mem_addr       (mem_addr),
    .mem_we         (mem_we),
    .mem_wdata      (mem_wdata),
    .busy           (busy),
    .done           (done),
    .fail           (fail),
    .fault_kind     (fault_kind),
    .victim_addr    (victim_addr),
    .aggressor_addr (aggressor_addr),
    .fail_data      (fail_data)
  );

endmodule

// File: tb/addr_bist_tb.sv
module addr_bist_tb;

  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail;
  logic [1:0]    fault_kind;
  logic [AW-1:0] victim_addr, aggressor_addr, mem_addr;
  logic [DW-1:0] fail_data, mem_wdata, mem_rdata;
  logic          mem_we;

  // Memory model with an injectable alias (0 off, 1 persistent, 2 one-shot)
  logic [DW-1:0] mem [N];
  int            alias_mode = 0;
  logic [AW-1:0] agg = '0, vic = '0;
  logic          scrub = 1'b0;
  logic          fired;
  int            zw;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  addr_bist #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fault_kind(fault_kind), .victim_addr(victim_addr),
    .aggressor_addr(aggressor_addr), .fail_data(fail_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (scrub) begin
      for (int i = 0; i < N; i++) mem[i] <= 8'h5A;
      fired <= 1'b0;
      zw    <= 0;
    end else begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (mem_wdata == '0) zw <= zw + 1;
        if (alias_mode != 0 && mem_addr == agg && !(alias_mode == 2 && fired)) begin
          mem[vic] <= mem_wdata;
          if (alias_mode == 2 && mem_wdata != '0) fired <= 1'b1;
        end
      end
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int v, input int mode, input bit poke);
    int cnt;
    @(negedge clk);
    alias_mode = mode; agg = AW'(a); vic = AW'(v); scrub = 1'b1;
    @(negedge clk);
    scrub = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check("R3 run finished (watchdog)", done, 1);
  endtask

  task automatic check_clean(input string tag);
    check({tag, " R3 fail"}, fail, 0);
    check({tag, " R3 kind"}, fault_kind, 0);
    check({tag, " R9 zero writes"}, zw, 2 * N);
    for (int i = 0; i < N; i++) check({tag, " R3 all ones"}, mem[i], 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 fail", fail, 0);
    check("R1 we", mem_we, 0);
    check("R1 kind", fault_kind, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 0, 0, 1'b0);
    check_clean("clean");

    for (int a = 0; a < N; a++) begin
      for (int v = 0; v < N; v++) begin
        if (a != v) begin
          run(a, v, 1, 1'b0);
          check("R4 R5 fail", fail, 1);
          check(a < v ? "R4 kind" : "R5 kind", fault_kind, a < v ? 1 : 2);
          check(a < v ? "R4 victim" : "R5 victim", victim_addr, v);
          check(a < v ? "R4 aggressor" : "R5 aggressor", aggressor_addr, a);
          check("R4 fail_data", fail_data, 8'hFF);
          check("R9 zero writes", zw, a < v ? 2 * N : 3 * N);
          repeat (3) @(negedge clk);
          check("R10 done held", done, 1);
          check("R10 victim held", victim_addr, v);
        end
      end
    end

    for (int a = 0; a < N; a++) begin
      for (int v = a + 1; v < N; v++) begin
        run(a, v, 2, 1'b0);
        check("R6 R7 transient kind", fault_kind, 3);
        check("R6 victim", victim_addr, v);
        check("R6 fail", fail, 1);
        check("R9 zero writes", zw, 2 * N);
      end
    end

    run(0, 0, 0, 1'b1);
    check_clean("restart ignored R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule